// File: doc/BRIEF.md
# Extended-Data-Out DRAM Page Sequencer

This block sits between a simple word request port and a 16-bit-wide extended-data-out DRAM with a 20-bit word address. It splits each word address into a row half and a column half. Both halves go out on one shared set of address pins: the row is presented when the row strobe falls and the column when a column strobe falls. Every DRAM timing rule is held as a whole number of clock cycles, given by parameters.

After a row is opened it stays open. Later requests to the same row go straight to a column access, with no row cycle in between. A request to another row first closes the open row, waits out the precharge time and then opens the new row. Writes are early writes: the write strobe is low before the column strobe falls, and the output enable stays high. The two byte-enable bits drive the upper and lower column strobes separately. Read data is sampled once the slowest access-time limit has passed, and is returned with a one-cycle valid pulse.

The open row is also closed when a refresh grant arrives, and when the row has been low for close to its maximum allowed time. In both cases the block then reports idle.

Top module: `edo_page_seq`

## Requirements
- R1: After reset, the row strobe, both column strobes, the write strobe and the output enable are high, the data drive is off, `idle` is 1, and `req_ack` and `rsp_valid` are 0.
- R2: Opening a row drives the row address `req_addr[19:10]` on the address pins as the row strobe falls. At least `T_RCD` cycles later, the column strobe falls with `req_addr[9:0]` on the pins.
- R3: A request whose row equals the open row is served without toggling the row strobe. Its read result arrives RD_CAS = max(`T_CAC`, `T_AA`, `T_CPA`-`T_CP`) cycles after the acknowledge cycle.
- R4: A request for a different row raises the row strobe and keeps it high for at least `T_RP` cycles, then reopens with a new row strobe fall.
- R5: A read that opens a row returns its data max(`T_RCD`+RD_CAS, `T_RAC`) cycles after its acknowledge. Every read result is a single-cycle `rsp_valid` pulse carrying the addressed word.
- R6: In a write, `req_be[1]` drives the upper column strobe (data bits 15:8) and `req_be[0]` drives the lower one (bits 7:0). A disabled lane's strobe stays high, so that byte is unchanged. Reads drive both strobes.
- R7: Writes are early writes. At every column strobe fall of a write, the write strobe is already low, the output enable is high and the data drive is on.
- R8: Between two column accesses in one open row, the column strobes stay high for at least max(`T_CP`, `T_PC` minus the shortest column-low time) cycles.
- R9: While `refresh_grant` is 1, no request is acknowledged. An open row is closed once it has been low at least `T_RAS_MIN` cycles, and `idle` returns to 1 after the precharge.
- R10: The row strobe never stays low longer than `T_RAS_MAX` cycles. An idle open row closes after exactly `T_RAS_MAX` - RD_CAS - CP cycles low.
- R11: Every row strobe low period lasts at least `T_RAS_MIN` cycles.
- R12: `req_ack` is a one-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request pending, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in the upper half |
| req_be | input | 2 | Byte enables, bit 1 = upper byte |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | Request accepted (one-cycle pulse) |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata | output | 16 | Read data |
| refresh_grant | input | 1 | Close the row and stay idle |
| idle | output | 1 | No row open, no access in progress |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower byte column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Write data to the DRAM |
| dram_dq_oe | output | 1 | Data pin drive enable |
| dram_dq_in | input | 16 | Read data from the DRAM |

## Verification
Read results are due a fixed number of cycles after the cycle `req_ack` is seen: RD_CAS cycles on a page hit and max(`T_RCD`+RD_CAS, `T_RAC`) cycles when a row has to be opened. The bench counts clock edges from the acknowledge to the `rsp_valid` pulse and compares the count with the value it computed, sampling on falling edges so that each registered output is read in the cycle after the edge that set it. Strobe run lengths are measured by a DRAM model that counts falling edges. The byte-lane strobe counts are read a few cycles after each write, once its column strobe has certainly fallen. The idle row-close time is compared with the exact cycle count computed in the bench.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RCD,
        ST_CAS,
        ST_CP,
        ST_OPEN,
        ST_PRE
    } seq_state_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_sat_counter.sv
module edo_sat_counter #(
    parameter int MAX = 255,
    parameter int W   = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = W'(MAX);

    logic [W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr)
            count_d = '0;
        else if (en && count_q != TOP)
            count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
    parameter int PIN_W = 10
) (
    input  logic [2*PIN_W-1:0] addr,
    input  logic [PIN_W-1:0]   open_row,
    output logic [PIN_W-1:0]   row,
    output logic [PIN_W-1:0]   col,
    output logic               hit
);
    assign row = addr[2*PIN_W-1:PIN_W];
    assign col = addr[PIN_W-1:0];
    assign hit = (row == open_row);
endmodule

// File: rtl/edo_page_seq.sv
module edo_page_seq
    import edo_seq_pkg::*;
#(
    parameter int PIN_W     = 10,
    parameter int DATA_W    = 16,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 3,
    parameter int T_RAS_MIN = 5,
    parameter int T_RAS_MAX = 20000,
    parameter int T_CAS     = 1,
    parameter int T_CP      = 1,
    parameter int T_PC      = 2,
    parameter int T_CAC     = 2,
    parameter int T_AA      = 3,
    parameter int T_RAC     = 5,
    parameter int T_CPA     = 3,
    parameter int T_DH      = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [2*PIN_W-1:0]  req_addr,
    input  logic [1:0]          req_be,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ack,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic                refresh_grant,
    output logic                idle,
    output logic                dram_ras_n,
    output logic                dram_ucas_n,
    output logic                dram_lcas_n,
    output logic                dram_we_n,
    output logic                dram_oe_n,
    output logic [PIN_W-1:0]    dram_addr,
    output logic [DATA_W-1:0]   dram_dq_out,
    output logic                dram_dq_oe,
    input  logic [DATA_W-1:0]   dram_dq_in
);
    // Column-low cycles for reads and writes, and the enforced CAS-high time
    localparam int RD_CAS    = imax(imax(T_CAC, T_AA), imax(T_CPA - T_CP, T_CAS));
    localparam int WR_CAS    = imax(T_CAS, T_DH);
    localparam int CP_EFF    = imax(T_CP, T_PC - ((RD_CAS < WR_CAS) ? RD_CAS : WR_CAS));
    // Last row age at which an idle open row may stay open
    localparam int RAS_CLOSE = T_RAS_MAX - RD_CAS - CP_EFF - 1;
    localparam int AGE_W     = $clog2(T_RAS_MAX + 1);
    localparam int CNT_W     = $clog2(T_RP + T_RCD + RD_CAS + WR_CAS + CP_EFF + 1);

    localparam logic [AGE_W-1:0] AGE_RAC   = AGE_W'(T_RAC - 1);
    localparam logic [AGE_W-1:0] AGE_MIN   = AGE_W'(T_RAS_MIN - 1);
    localparam logic [AGE_W-1:0] AGE_CLOSE = AGE_W'(RAS_CLOSE);

    typedef struct packed {
        seq_state_t          state;
        logic [CNT_W-1:0]    cnt;
        logic                ras_n;
        logic                ucas_n;
        logic                lcas_n;
        logic                we_n;
        logic                oe_n;
        logic                dq_oe;
        logic                ack;
        logic                rsp_valid;
        logic                write;
        logic [1:0]          be;
        logic [PIN_W-1:0]    addr;
        logic [PIN_W-1:0]    open_row;
        logic [PIN_W-1:0]    col;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
    } seq_regs_t;

    seq_regs_t n_d, r_q;

    logic [PIN_W-1:0] req_row, req_col;
    logic             row_hit;
    logic [AGE_W-1:0] age_q;
    logic             age_clr;
    logic             take;
    logic             go_col;
    logic             sel_wr;
    logic [1:0]       sel_be;
    logic             close_row;

    edo_addr_split #(.PIN_W(PIN_W)) u_split (
        .addr     (req_addr),
        .open_row (r_q.open_row),
        .row      (req_row),
        .col      (req_col),
        .hit      (row_hit)
    );

    edo_sat_counter #(.MAX(T_RAS_MAX), .W(AGE_W)) u_ras_age (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (age_clr),
        .en    (!r_q.ras_n),
        .count (age_q)
    );

    always_comb begin
        n_d           = r_q;
        n_d.ack       = 1'b0;
        n_d.rsp_valid = 1'b0;
        age_clr       = 1'b0;
        take          = 1'b0;
        go_col        = 1'b0;
        close_row     = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                if (req_valid && !refresh_grant) begin
                    take         = 1'b1;
                    age_clr      = 1'b1;
                    n_d.ras_n    = 1'b0;
                    n_d.addr     = req_row;
                    n_d.open_row = req_row;
                    n_d.cnt      = CNT_W'(T_RCD - 1);
                    n_d.state    = ST_RCD;
                end
            end
            ST_RCD: begin
                if (r_q.cnt == '0) go_col = 1'b1;
                else               n_d.cnt = r_q.cnt - 1'b1;
            end
            ST_CAS: begin
                if (r_q.cnt != '0) begin
                    n_d.cnt = r_q.cnt - 1'b1;
                end else if (r_q.write || age_q >= AGE_RAC) begin
                    n_d.ucas_n = 1'b1;
                    n_d.lcas_n = 1'b1;
                    n_d.we_n   = 1'b1;
                    n_d.oe_n   = 1'b1;
                    n_d.dq_oe  = 1'b0;
                    if (!r_q.write) begin
                        n_d.rsp_valid = 1'b1;
                        n_d.rdata     = dram_dq_in;
                    end
                    n_d.cnt   = CNT_W'(CP_EFF - 1);
                    n_d.state = ST_CP;
                end
            end
            ST_CP: begin
                if (r_q.cnt == '0) n_d.state = ST_OPEN;
                else               n_d.cnt = r_q.cnt - 1'b1;
            end
            ST_OPEN: begin
                close_row = refresh_grant || (age_q >= AGE_CLOSE) || (req_valid && !row_hit);
                if (close_row) begin
                    if (age_q >= AGE_MIN) begin
                        n_d.ras_n = 1'b1;
                        n_d.cnt   = CNT_W'(T_RP - 1);
                        n_d.state = ST_PRE;
                    end
                end else if (req_valid) begin
                    take   = 1'b1;
                    go_col = 1'b1;
                end
            end
            ST_PRE: begin
                if (r_q.cnt == '0) n_d.state = ST_IDLE;
                else               n_d.cnt = r_q.cnt - 1'b1;
            end
            default: n_d.state = ST_IDLE;
        endcase

        if (take) begin
            n_d.ack   = 1'b1;
            n_d.write = req_write;
            n_d.be    = req_be;
            n_d.wdata = req_wdata;
            n_d.col   = req_col;
        end

        sel_wr = take ? req_write : r_q.write;
        sel_be = take ? req_be    : r_q.be;
        if (go_col) begin
            n_d.addr   = take ? req_col : r_q.col;
            n_d.ucas_n = sel_wr ? !sel_be[1] : 1'b0;
            n_d.lcas_n = sel_wr ? !sel_be[0] : 1'b0;
            n_d.we_n   = !sel_wr;
            n_d.oe_n   = sel_wr;
            n_d.dq_oe  = sel_wr;
            n_d.cnt    = sel_wr ? CNT_W'(WR_CAS - 1) : CNT_W'(RD_CAS - 1);
            n_d.state  = ST_CAS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= ST_IDLE;
            r_q.ras_n  <= 1'b1;
            r_q.ucas_n <= 1'b1;
            r_q.lcas_n <= 1'b1;
            r_q.we_n   <= 1'b1;
            r_q.oe_n   <= 1'b1;
        end else begin
            r_q <= n_d;
        end
    end

    assign req_ack     = r_q.ack;
    assign rsp_valid   = r_q.rsp_valid;
    assign rsp_rdata   = r_q.rdata;
    assign idle        = (r_q.state == ST_IDLE);
    assign dram_ras_n  = r_q.ras_n;
    assign dram_ucas_n = r_q.ucas_n;
    assign dram_lcas_n = r_q.lcas_n;
    assign dram_we_n   = r_q.we_n;
    assign dram_oe_n   = r_q.oe_n;
    assign dram_addr   = r_q.addr;
    assign dram_dq_out = r_q.wdata;
    assign dram_dq_oe  = r_q.dq_oe;
endmodule

// File: rtl/edo_page_seq_chk.sv
module edo_page_seq_chk #(
    parameter int T_RCD     = 2,
    parameter int T_RP      = 3,
    parameter int T_RAS_MIN = 5,
    parameter int T_RAS_MAX = 20000,
    parameter int CP_MIN    = 1
) (
    input logic clk,
    input logic rst_n,
    input logic req_ack,
    input logic rsp_valid,
    input logic refresh_grant,
    input logic dram_ras_n,
    input logic dram_ucas_n,
    input logic dram_lcas_n,
    input logic dram_we_n,
    input logic dram_oe_n,
    input logic dram_dq_oe
);
    localparam int RW = $clog2(T_RAS_MAX + 2);

    logic          cas_any;
    logic [RW-1:0] lo_q, hi_q, chi_q;

    assign cas_any = !dram_ucas_n || !dram_lcas_n;

    // Run-length counters of the strobes, measured from the registered pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= RW'(T_RP);
            chi_q <= RW'(T_RAS_MAX + 1);
        end else begin
            lo_q  <= dram_ras_n ? '0 : ((lo_q == RW'(T_RAS_MAX + 1)) ? lo_q : lo_q + 1'b1);
            hi_q  <= !dram_ras_n ? '0 : ((hi_q == RW'(T_RAS_MAX + 1)) ? hi_q : hi_q + 1'b1);
            chi_q <= dram_ras_n ? RW'(T_RAS_MAX + 1) :
                     cas_any    ? '0 :
                     ((chi_q == RW'(T_RAS_MAX + 1)) ? chi_q : chi_q + 1'b1);
        end
    end

    p_cas_in_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cas_any |-> !dram_ras_n);
    p_rcd_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_any) |-> lo_q >= RW'(T_RCD));
    p_precharge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> hi_q >= RW'(T_RP));
    p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_early_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cas_any) && dram_dq_oe) |-> (!dram_we_n && dram_oe_n));
    p_cas_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_any) |-> chi_q >= RW'(CP_MIN));
    p_grant_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_grant |=> !req_ack);
    p_ras_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lo_q <= RW'(T_RAS_MAX));
    p_ras_min_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> lo_q >= RW'(T_RAS_MIN));
    p_ack_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);
endmodule

bind edo_page_seq edo_page_seq_chk #(
    .T_RCD     (T_RCD),
    .T_RP      (T_RP),
    .T_RAS_MIN (T_RAS_MIN),
    .T_RAS_MAX (T_RAS_MAX),
    .CP_MIN    (CP_EFF)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ack       (req_ack),
    .rsp_valid     (rsp_valid),
    .refresh_grant (refresh_grant),
    .dram_ras_n    (dram_ras_n),
    .dram_ucas_n   (dram_ucas_n),
    .dram_lcas_n   (dram_lcas_n),
    .dram_we_n     (dram_we_n),
    .dram_oe_n     (dram_oe_n),
    .dram_dq_oe    (dram_dq_oe)
);

// File: tb/edo_page_seq_test.sv
module edo_page_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int T_RCD = 2, T_RP = 3, T_RAS_MIN = 5, T_RAS_MAX = 200;
    localparam int T_CP = 1, T_PC = 2, T_CAS = 1, T_CAC = 2, T_AA = 3, T_RAC = 5, T_CPA = 3, T_DH = 1;
    localparam int RD_LAT   = 3;  // max(T_CAC, T_AA, T_CPA - T_CP)
    localparam int OPEN_LAT = (T_RCD + RD_LAT > T_RAC) ? T_RCD + RD_LAT : T_RAC;
    localparam int CP_MIN   = 1;  // max(T_CP, T_PC - 1)
    localparam int IDLE_LO  = T_RAS_MAX - RD_LAT - CP_MIN;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, refresh_grant = 0;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic req_ack, rsp_valid, idle, ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe;
    logic [15:0] rsp_rdata, dq_out, dq_in;
    logic [9:0]  dram_addr;

    edo_page_seq #(.T_RAS_MAX(T_RAS_MAX)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .req_ack(req_ack),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .refresh_grant(refresh_grant),
        .idle(idle), .dram_ras_n(ras_n), .dram_ucas_n(ucas_n), .dram_lcas_n(lcas_n),
        .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(dram_addr), .dram_dq_out(dq_out),
        .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // DRAM model and strobe monitors, sampled mid-cycle
    logic [15:0] mem [64];
    logic [9:0]  m_row = '0, m_col = '0;
    logic p_ras = 1, p_cas = 0;
    int ras_falls = 0, u_falls = 0, l_falls = 0;
    int lo_cnt = 0, hi_cnt = 0, chi_cnt = 0, last_lo = 0, min_lo = 1 << 30, max_lo = 0, min_hi = 1 << 30;
    int rcd_bad = 0, ew_bad = 0, cp_bad = 0, ack_run = 0, ack_bad = 0;
    bit first_cas = 1;

    assign dq_in = (!oe_n && (!ucas_n || !lcas_n)) ? mem[{m_row[1:0], m_col[3:0]}] : 16'h0000;

    always @(negedge clk) if (rst_n) begin
        if (!ras_n && p_ras) begin
            m_row = dram_addr; ras_falls++; first_cas = 1;
            if (hi_cnt < min_hi) min_hi = hi_cnt;
        end
        if ((!ucas_n || !lcas_n) && !p_cas) begin
            m_col = dram_addr;
            if (lo_cnt < T_RCD) rcd_bad++;
            if (!first_cas && chi_cnt < CP_MIN) cp_bad++;
            first_cas = 0;
            if (!ucas_n) u_falls++;
            if (!lcas_n) l_falls++;
            if (dq_oe && !(!we_n && oe_n)) ew_bad++;
            if (!we_n) begin
                if (!ucas_n) mem[{m_row[1:0], m_col[3:0]}][15:8] = dq_out[15:8];
                if (!lcas_n) mem[{m_row[1:0], m_col[3:0]}][7:0]  = dq_out[7:0];
            end
        end
        if (ras_n && lo_cnt > 0) begin
            last_lo = lo_cnt;
            if (lo_cnt < min_lo) min_lo = lo_cnt;
            if (lo_cnt > max_lo) max_lo = lo_cnt;
        end
        lo_cnt  = ras_n ? 0 : lo_cnt + 1;
        hi_cnt  = ras_n ? hi_cnt + 1 : 0;
        chi_cnt = (!ucas_n || !lcas_n) ? 0 : chi_cnt + 1;
        ack_run = req_ack ? ack_run + 1 : 0;
        if (ack_run > 1) ack_bad++;
        p_ras = ras_n;
        p_cas = !ucas_n || !lcas_n;
    end

    function automatic logic [15:0] pat(input int r, input int c);
        return {4'(r + 1), 4'(c), 8'(r * 16 + c + 3)};
    endfunction

    int ack_cyc;
    int cur_row = -1;

    task automatic issue(input bit wr, input int r, input int c, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = {10'(r), 10'(c)}; req_be = be; req_wdata = d;
        do @(negedge clk); while (!req_ack);
        ack_cyc = cyc;
        req_valid = 0;
    endtask

    task automatic do_read(input int r, input int c, input logic [15:0] exp, input string tag);
        int exp_lat, f0;
        exp_lat = (r == cur_row) ? RD_LAT : OPEN_LAT;
        f0 = ras_falls;
        issue(0, r, c, 2'b11, 16'h0);
        do @(negedge clk); while (!rsp_valid);
        chk(rsp_rdata == exp, {tag, " R5 data"}, rsp_rdata, exp);
        chk(cyc - ack_cyc == exp_lat, (r == cur_row) ? "R3 hit latency" : "R5 open latency", cyc - ack_cyc, exp_lat);
        if (r == cur_row) chk(ras_falls == f0, "R3 no row strobe on hit", ras_falls, f0);
        else              chk(ras_falls == f0 + 1, "R4 reopen on miss", ras_falls, f0 + 1);
        cur_row = r;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        chk(ras_n && ucas_n && lcas_n && we_n && oe_n && !dq_oe, "R1 strobes in reset", {ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe}, 6'b111110);
        rst_n = 1;
        @(negedge clk);
        chk(idle == 1 && req_ack == 0 && rsp_valid == 0, "R1 idle after reset", {idle, req_ack, rsp_valid}, 3'b100);

        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 8; c++) begin
                issue(1, r, c, 2'b11, pat(r, c));
                cur_row = r;
            end
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 4; r++) do_read(r, c, pat(r, c), "R2 column sweep");
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 8; c++) do_read(r, c, pat(r, c), "R2 row sweep");

        // Byte lanes
        begin
            int u0, l0;
            u0 = u_falls; l0 = l_falls;
            issue(1, 1, 2, 2'b10, 16'h5AC3); cur_row = 1;
            repeat (4) @(negedge clk);
            chk(u_falls == u0 + 1 && l_falls == l0, "R6 upper lane only", l_falls - l0, 0);
            do_read(1, 2, {8'h5A, pat(1, 2)[7:0]}, "R6 upper merge");
            u0 = u_falls; l0 = l_falls;
            issue(1, 1, 2, 2'b01, 16'h0F96);
            repeat (4) @(negedge clk);
            chk(l_falls == l0 + 1 && u_falls == u0, "R6 lower lane only", u_falls - u0, 0);
            do_read(1, 2, 16'h5A96, "R6 lower merge");
        end

        // Refresh grant
        refresh_grant = 1;
        repeat (20) @(negedge clk);
        chk(ras_n == 1 && idle == 1, "R9 row closed for refresh", {ras_n, idle}, 2'b11);
        begin
            int acks = 0;
            req_valid = 1; req_write = 0; req_addr = {10'd0, 10'd0}; req_be = 2'b11;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (req_ack) acks++;
            end
            req_valid = 0;
            chk(acks == 0, "R9 no ack under grant", acks, 0);
        end
        @(negedge clk);
        refresh_grant = 0;
        cur_row = -1;

        // Idle row timeout
        issue(1, 2, 9, 2'b11, 16'hBEEF);
        repeat (T_RAS_MAX + 40) @(negedge clk);
        chk(ras_n == 1, "R10 idle row closed", ras_n, 1);
        chk(last_lo == IDLE_LO, "R10 close time", last_lo, IDLE_LO);
        chk(max_lo <= T_RAS_MAX, "R10 longest row low", max_lo, T_RAS_MAX);
        do_read(2, 9, 16'hBEEF, "R10 after timeout");

        repeat (5) @(negedge clk);
        chk(rcd_bad == 0, "R2 row to column gap", rcd_bad, 0);
        chk(min_hi >= T_RP, "R4 precharge length", min_hi, T_RP);
        chk(ew_bad == 0, "R7 early write strobes", ew_bad, 0);
        chk(cp_bad == 0, "R8 column high time", cp_bad, 0);
        chk(min_lo >= T_RAS_MIN, "R11 shortest row low", min_lo, T_RAS_MIN);
        chk(ack_bad == 0, "R12 ack pulse width", ack_bad, 0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule